// File: doc/BRIEF.md
# Zoned Data Store Access Controller

This block serves the two data-access commands of a secure element, a zone read and a zone update, after the frame layer has already checked the frame's integrity. It receives a decoded request made of an operation flag, a zone index, a 16-bit start offset and a 16-bit byte count. It checks the request against the size of the addressed zone and against a write policy. It then either streams bytes out of an internal byte-wide store or takes bytes into that store. A one-byte status code always goes back to the response builder, together with any data bytes.

The store is split into five zones: device certificate (index 0), manufacturer certificate (1), root certificate (2), product data (3) and user data (4). Zone sizes are parameters, with defaults of 512, 512, 512, 64 and 256 bytes. A synchronous reset loads every zone from computed constants. Only the user-data zone can be changed. Every illegal request is answered with an error code before any byte of the store is touched.

Top module: `zds_access_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_ready` is 1 and `sts_valid`, `rd_valid` and `wr_ready` are 0.
- R2: After reset, byte `a` of zone 3 is the product identifier, big-endian, for `a` from 6 to 9, and 0 everywhere else. Byte `a` of any other zone `z` is `(a + 59*z) mod 256`.
- R3: A legal read is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. In the next cycle `sts_valid` is 1 with code 0x00. In each of the following `length` cycles `rd_valid` is 1 and carries the zone bytes from the offset upward, with `rd_last` set on the final byte only.
- R4: A read of zone 3 at offset 2 with length 8 returns four 0x00 bytes and then the four bytes of `PRODUCT_ID`, most significant byte first.
- R5: A zone index above 4 returns status 0x02.
- R6: A byte count of zero returns status 0x02, for a read and for an update.
- R7: When offset plus length is larger than the zone size, status 0x02 is returned.
- R8: A read whose length is larger than `MAX_RESP - 5` returns status 0x06. This test runs after the index, zero-length and write-policy tests and before the bounds test.
- R9: An update to zones 0 to 3 returns status 0x02, and the store is left unchanged.
- R10: A legal update to zone 4 raises `wr_ready`. It takes one byte on each edge where `wr_valid` and `wr_ready` are both 1, until `length` bytes have been taken. In the next cycle it reports status 0x00, and it returns no data.
- R11: Bytes written by an update are returned by a read issued in the very next command.
- R12: A refused request produces exactly one status cycle, no data bytes and no `wr_ready`, and `cmd_ready` returns in the cycle after the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block idle, request accepted on this edge |
| cmd_update | input | 1 | 1 = update, 0 = read |
| cmd_zone | input | 8 | Zone index |
| cmd_offset | input | 16 | Start byte within the zone |
| cmd_length | input | 16 | Byte count |
| wr_valid | input | 1 | Update payload byte present |
| wr_ready | output | 1 | Payload byte taken on this edge |
| wr_data | input | 8 | Update payload byte |
| sts_valid | output | 1 | Status code valid (one cycle) |
| sts_code | output | 8 | 0x00 ok, 0x02 bad argument, 0x06 too long |
| rd_valid | output | 1 | Read data byte valid |
| rd_last | output | 1 | Final read data byte |
| rd_data | output | 8 | Read data byte |

## Verification
A wrong start address or pointer shows up in the first data byte of the next read, one cycle after the status. A stray write is not visible at once. It appears only when a later read of the damaged zone returns a byte that differs from the preload formula or from the last legal update. For that reason, every update in the sweeps is followed by reads of the whole target zone. A wrong remaining-count register shows up as a missing or extra `rd_valid` cycle, or as `rd_last` in the wrong place, within the same command. A bad check decision shows up in the status byte one cycle after the request is accepted.

// File: rtl/zds_pkg.sv
package zds_pkg;

    localparam int NZ       = 5;
    localparam int OVERHEAD = 5;

    typedef enum logic [7:0] {
        ST_OK      = 8'h00,
        ST_BADARG  = 8'h02,
        ST_TOOLONG = 8'h06
    } status_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_REPORT,
        PH_READ,
        PH_WRITE
    } phase_e;

    typedef struct packed {
        logic        write;
        logic [7:0]  zone;
        logic [15:0] offset;
        logic [15:0] length;
    } req_t;

    typedef logic [NZ-1:0][15:0] zsizes_t;

    function automatic int unsigned zone_base(input zsizes_t sizes, input int z);
        int unsigned acc = 0;
        for (int i = 0; i < NZ; i++)
            if (i < z) acc += int'(sizes[i]);
        return acc;
    endfunction

    function automatic int unsigned total_size(input zsizes_t sizes);
        return zone_base(sizes, NZ);
    endfunction

    function automatic logic [7:0] init_byte(input int z, input int unsigned a,
                                             input logic [31:0] pid);
        if (z == 3) begin
            case (a)
                6:       return pid[31:24];
                7:       return pid[23:16];
                8:       return pid[15:8];
                9:       return pid[7:0];
                default: return 8'h00;
            endcase
        end
        return 8'(a) + 8'(59 * z);
    endfunction

    function automatic logic [7:0] init_at(input zsizes_t sizes, input int unsigned addr,
                                           input logic [31:0] pid);
        logic [7:0] v = 8'h00;
        for (int z = 0; z < NZ; z++) begin
            if (addr >= zone_base(sizes, z) && addr < zone_base(sizes, z) + int'(sizes[z]))
                v = init_byte(z, addr - zone_base(sizes, z), pid);
        end
        return v;
    endfunction

endpackage

// File: rtl/zds_checker.sv
module zds_checker
    import zds_pkg::*;
#(
    parameter zsizes_t     ZONE_SIZES = {16'd256, 16'd64, 16'd512, 16'd512, 16'd512},
    parameter int          WR_ZONE    = 4,
    parameter int          RD_MAX     = 507,
    parameter int          AW         = 11
) (
    input  req_t             req,
    output status_e          status,
    output logic [AW-1:0]    start_addr
);

    logic [NZ-1:0]   hit;
    logic [NZ-1:0]   fits;
    logic [AW-1:0]   base_arr [NZ];
    logic [16:0]     end_pos;

    assign end_pos = {1'b0, req.offset} + {1'b0, req.length};

    for (genvar z = 0; z < NZ; z++) begin : g_zone
        assign hit[z]      = (req.zone == 8'(z));
        assign fits[z]     = (end_pos <= {1'b0, ZONE_SIZES[z]});
        assign base_arr[z] = AW'(zone_base(ZONE_SIZES, z));
    end

    logic zone_ok, in_bounds, protected_zone;

    always_comb begin
        start_addr = '0;
        for (int z = 0; z < NZ; z++)
            if (hit[z]) start_addr = base_arr[z] + AW'(req.offset);
    end

    assign zone_ok        = |hit;
    assign in_bounds      = |(hit & fits);
    assign protected_zone = req.zone != 8'(WR_ZONE);

    always_comb begin
        if (!zone_ok || req.length == 16'd0 || (req.write && protected_zone))
            status = ST_BADARG;
        else if (!req.write && int'(req.length) > RD_MAX)
            status = ST_TOOLONG;
        else if (!in_bounds)
            status = ST_BADARG;
        else
            status = ST_OK;
    end

endmodule

// File: rtl/zds_store.sv
module zds_store
    import zds_pkg::*;
#(
    parameter zsizes_t     ZONE_SIZES = {16'd256, 16'd64, 16'd512, 16'd512, 16'd512},
    parameter logic [31:0] PRODUCT_ID = 32'h41FF_E56F,
    parameter int          WR_ZONE    = 4,
    parameter int          AW         = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    localparam int unsigned TOTAL     = total_size(ZONE_SIZES);
    localparam int unsigned USER_LO   = zone_base(ZONE_SIZES, WR_ZONE);
    localparam int unsigned USER_HI   = USER_LO + int'(ZONE_SIZES[WR_ZONE]);

    logic [7:0] mem [TOTAL];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(TOTAL); i++)
                mem[i] <= init_at(ZONE_SIZES, i, PRODUCT_ID);
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    // Only the writable zone may ever receive a store write.
    assert_write_user_only_R9: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(addr) >= int'(USER_LO) && int'(addr) < int'(USER_HI)));

endmodule

// File: rtl/zds_sequencer.sv
module zds_sequencer
    import zds_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          req_write,
    input  logic [15:0]   req_length,
    input  status_e       chk_status,
    input  logic [AW-1:0] chk_addr,
    input  logic          wr_valid,
    output logic          cmd_ready,
    output logic          sts_valid,
    output logic [7:0]    sts_code,
    output logic          rd_valid,
    output logic          rd_last,
    output logic          wr_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr
);

    phase_e        phase;
    logic [AW-1:0] ptr;
    logic [15:0]   remain;
    status_e       code;
    logic          rd_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            ptr     <= '0;
            remain  <= '0;
            code    <= ST_OK;
            rd_pend <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (cmd_valid) begin
                    code    <= chk_status;
                    ptr     <= chk_addr;
                    remain  <= req_length;
                    rd_pend <= (chk_status == ST_OK) && !req_write;
                    phase   <= (chk_status == ST_OK && req_write) ? PH_WRITE : PH_REPORT;
                end
                PH_REPORT: begin
                    phase   <= rd_pend ? PH_READ : PH_IDLE;
                    rd_pend <= 1'b0;
                end
                PH_READ: begin
                    ptr    <= ptr + 1'b1;
                    remain <= remain - 1'b1;
                    if (remain == 16'd1) phase <= PH_IDLE;
                end
                PH_WRITE: if (wr_valid) begin
                    ptr    <= ptr + 1'b1;
                    remain <= remain - 1'b1;
                    if (remain == 16'd1) phase <= PH_REPORT;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign cmd_ready = (phase == PH_IDLE);
    assign sts_valid = (phase == PH_REPORT);
    assign sts_code  = code;
    assign rd_valid  = (phase == PH_READ);
    assign rd_last   = (phase == PH_READ) && (remain == 16'd1);
    assign wr_ready  = (phase == PH_WRITE);
    assign mem_we    = (phase == PH_WRITE) && wr_valid;
    assign mem_addr  = ptr;

    assert_single_status_R12: assert property (@(posedge clk) disable iff (rst)
        sts_valid |=> !sts_valid);

    assert_exclusive_outputs_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_ready, sts_valid, rd_valid, wr_ready}));

    assert_refused_returns_R12: assert property (@(posedge clk) disable iff (rst)
        (sts_valid && sts_code != 8'h00) |=> cmd_ready);

    assert_last_then_idle_R3: assert property (@(posedge clk) disable iff (rst)
        rd_last |=> cmd_ready);

endmodule

// File: rtl/zds_access_ctrl.sv
module zds_access_ctrl
    import zds_pkg::*;
#(
    parameter zsizes_t     ZONE_SIZES = {16'd256, 16'd64, 16'd512, 16'd512, 16'd512},
    parameter int          WR_ZONE    = 4,
    parameter int          MAX_RESP   = 512,
    parameter logic [31:0] PRODUCT_ID = 32'h41FF_E56F
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic        cmd_update,
    input  logic [7:0]  cmd_zone,
    input  logic [15:0] cmd_offset,
    input  logic [15:0] cmd_length,
    input  logic        wr_valid,
    output logic        wr_ready,
    input  logic [7:0]  wr_data,
    output logic        sts_valid,
    output logic [7:0]  sts_code,
    output logic        rd_valid,
    output logic        rd_last,
    output logic [7:0]  rd_data
);

    localparam int unsigned TOTAL  = total_size(ZONE_SIZES);
    localparam int          AW     = $clog2(TOTAL);
    localparam int          RD_MAX = MAX_RESP - OVERHEAD;

    req_t          req;
    status_e       chk_status;
    logic [AW-1:0] chk_addr;
    logic          mem_we;
    logic [AW-1:0] mem_addr;

    assign req = '{write: cmd_update, zone: cmd_zone, offset: cmd_offset, length: cmd_length};

    zds_checker #(
        .ZONE_SIZES (ZONE_SIZES),
        .WR_ZONE    (WR_ZONE),
        .RD_MAX     (RD_MAX),
        .AW         (AW)
    ) u_check (
        .req        (req),
        .status     (chk_status),
        .start_addr (chk_addr)
    );

    zds_sequencer #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .req_write  (cmd_update),
        .req_length (cmd_length),
        .chk_status (chk_status),
        .chk_addr   (chk_addr),
        .wr_valid   (wr_valid),
        .cmd_ready  (cmd_ready),
        .sts_valid  (sts_valid),
        .sts_code   (sts_code),
        .rd_valid   (rd_valid),
        .rd_last    (rd_last),
        .wr_ready   (wr_ready),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr)
    );

    zds_store #(
        .ZONE_SIZES (ZONE_SIZES),
        .PRODUCT_ID (PRODUCT_ID),
        .WR_ZONE    (WR_ZONE),
        .AW         (AW)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (wr_data),
        .rdata (rd_data)
    );

    assert_zero_length_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_length == 16'd0) |=> (sts_valid && sts_code == 8'h02));

    assert_bad_zone_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_zone > 8'(NZ - 1)) |=> (sts_valid && sts_code == 8'h02));

    assert_oversize_read_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && !cmd_update && cmd_zone < 8'(NZ)
         && int'(cmd_length) > RD_MAX) |=> (sts_valid && sts_code == 8'h06));

endmodule

// File: tb/sim_zds_access_ctrl.sv
module sim_zds_access_ctrl;
    import zds_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAXR   = 32;
    localparam int RDMAX  = MAXR - 5;
    localparam logic [31:0] PID = 32'h41FF_E56F;
    localparam int SZ [5] = '{48, 16, 32, 32, 32};

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, cmd_update = 0, wr_valid = 0;
    logic [7:0] cmd_zone = 0, wr_data = 0;
    logic [15:0] cmd_offset = 0, cmd_length = 0;
    logic cmd_ready, wr_ready, sts_valid, rd_valid, rd_last;
    logic [7:0] sts_code, rd_data;

    int n_chk = 0, n_bad = 0;
    logic [7:0] model [5][64];
    logic [7:0] payload [1024];
    logic [7:0] got [1024];
    int n_got, n_taken, n_sts;
    bit frame_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    zds_access_ctrl #(
        .ZONE_SIZES ({16'd32, 16'd32, 16'd32, 16'd16, 16'd48}),
        .WR_ZONE    (4),
        .MAX_RESP   (MAXR),
        .PRODUCT_ID (PID)
    ) u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_init(input int z, input int a);
        if (z == 3) return (a >= 6 && a <= 9) ? PID[8*(9-a) +: 8] : 8'h00;
        return 8'(a + 59 * z);
    endfunction

    function automatic int exp_status(input bit w, input int z, input int off, input int len);
        if (z > 4 || len == 0 || (w && z != 4)) return 2;
        if (!w && len > RDMAX) return 6;
        if (off + len > SZ[z]) return 2;
        return 0;
    endfunction

    function automatic string tag_of(input bit w, input int z, input int off, input int len);
        if (z > 4) return "R5";
        if (len == 0) return "R6";
        if (w && z != 4) return "R9";
        if (!w && len > RDMAX) return "R8";
        if (off + len > SZ[z]) return "R7";
        return w ? "R10" : "R3";
    endfunction

    task automatic run_cmd(input bit w, input int z, input int off, input int len, output int st);
        int cyc = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_update = w; cmd_zone = 8'(z);
        cmd_offset = 16'(off); cmd_length = 16'(len);
        @(posedge clk);
        n_got = 0; n_taken = 0; n_sts = 0; st = -1; frame_ok = 1;
        forever begin
            @(negedge clk);
            cmd_valid = 0; wr_valid = 0;
            if (sts_valid) begin n_sts++; st = int'(sts_code); end
            if (rd_valid) begin
                if (n_sts == 0 || rd_last != (n_got == len - 1)) frame_ok = 0;
                if (n_got < 1024) got[n_got] = rd_data;
                n_got++;
            end
            if (wr_ready) begin
                wr_valid = 1; wr_data = payload[n_taken % 1024]; n_taken++;
            end
            if (cmd_ready && n_sts > 0) break;
            if (++cyc > 3000) begin frame_ok = 0; break; end
        end
    endtask

    task automatic do_read(input int z, input int off, input int len);
        int st, es; bit dok = 1;
        string t = tag_of(0, z, off, len);
        es = exp_status(0, z, off, len);
        run_cmd(0, z, off, len, st);
        check(st == es, t, st, es);
        check(frame_ok && n_sts == 1 && n_got == (es == 0 ? len : 0), t == "R3" ? "R3" : "R12",
              n_got, es == 0 ? len : 0);
        if (es == 0) begin
            for (int i = 0; i < len; i++) if (got[i] !== model[z][off+i]) dok = 0;
            check(dok, "R3 data", int'(got[0]), int'(model[z][off]));
        end
    endtask

    task automatic do_update(input int z, input int off, input int len, input int seed);
        int st, es;
        string t = tag_of(1, z, off, len);
        for (int i = 0; i < 1024; i++) payload[i] = 8'(seed * 7 + i * 13 + off);
        es = exp_status(1, z, off, len);
        run_cmd(1, z, off, len, st);
        check(st == es, t, st, es);
        check(frame_ok && n_sts == 1 && n_got == 0 && n_taken == (es == 0 ? len : 0),
              es == 0 ? "R10" : "R12", n_taken, es == 0 ? len : 0);
        if (es == 0) for (int i = 0; i < len; i++) model[z][off+i] = payload[i];
    endtask

    task automatic verify_zone(input int z);
        for (int c = 0; c < SZ[z]; c += 16) do_read(z, c, 16);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cmd_ready && !sts_valid && !rd_valid && !wr_ready, "R1 during reset",
              {cmd_ready, sts_valid, rd_valid, wr_ready}, 4'b1000);
        rst = 0;
        @(negedge clk);
        check(cmd_ready && !sts_valid && !rd_valid && !wr_ready, "R1 after reset",
              {cmd_ready, sts_valid, rd_valid, wr_ready}, 4'b1000);
        for (int z = 0; z < 5; z++) for (int a = 0; a < 64; a++) model[z][a] = ref_init(z, a);

        // R2: every zone matches the preload formula
        for (int z = 0; z < 5; z++) verify_zone(z);

        // R4: product identifier window
        begin
            int st; logic [63:0] v = '0;
            run_cmd(0, 3, 2, 8, st);
            for (int i = 0; i < 8; i++) v = {v[55:0], got[i]};
            check(st == 0 && n_got == 8 && v == {32'h0, PID}, "R4", int'(v[31:0]), int'(PID));
        end

        // near-exhaustive read sweep
        for (int z = 0; z < 7; z++) begin
            int sz = (z < 5) ? SZ[z] : 16;
            int zi = (z == 6) ? 255 : z;
            for (int off = 0; off <= sz + 1; off++) begin
                int lens [7] = '{0, 1, 3, sz - off, sz - off + 1, RDMAX, RDMAX + 1};
                foreach (lens[k]) if (lens[k] >= 0) do_read(zi, off, lens[k]);
            end
        end

        // update sweep, each followed by a full check of the target zone
        for (int z = 0; z < 6; z++) begin
            int sz = (z < 5) ? SZ[z] : 16;
            int offs [5] = '{0, 1, sz - 1, sz, sz + 1};
            foreach (offs[j]) begin
                int lens [5] = '{0, 1, 2, sz - offs[j], sz - offs[j] + 1};
                foreach (lens[k]) if (lens[k] >= 0) begin
                    do_update(z, offs[j], lens[k], j * 5 + k + z);
                    if (z < 5) verify_zone(z);
                end
            end
        end

        // R11: written bytes read back by the immediately following command
        begin
            int st;
            do_update(4, 10, 4, 99);
            run_cmd(0, 4, 10, 4, st);
            check(st == 0 && got[0] == payload[0] && got[3] == payload[3], "R11",
                  int'(got[3]), int'(payload[3]));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule